// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router

This block decides where a memory-mapped I/O request goes. It holds eight programmable windows. Each window is a pair of 32-bit registers: a lower-bound register and an upper-bound register. A request carries a 40-bit address, a read/write type and a flag that says whether the CPU issued it. The block compares address bits 39:16 against every window at once. It then reports whether a window claimed the request, which node and which link the request goes to, and whether a CPU write has to be issued as non-posted.

Software sets up the windows through a simple register port: one write strobe, a pair index, a select between lower and upper register, and write data. The register selected by the index and select is always visible on a read-data output. A lock bit in the lower-bound register protects its own pair. Once the lock is set, later writes to either register of that pair are dropped until reset. Requests are sampled on a clock edge and the answer is held for one cycle after that edge.

Top module: `mmio_route_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero. A request made after reset is answered with hit, error and non-posted all low.
- R2: A window matches when lower[31:8] <= A[39:16] <= upper[31:8]. Both bounds are inclusive and the granularity is 64 KB. An address one byte below the lower bound page misses, and so does the first byte of the page above the upper bound page.
- R3: Lower-bound bit 0 enables reads and bit 1 enables writes. A request only matches a window whose enable bit for its own type is set.
- R4: When lower-bound bit 2 is set, requests flagged as coming from the CPU do not match that window. Requests from other sources still match it.
- R5: On a hit, the node output is upper-bound bits 2:0 and the link output is upper-bound bits 5:4 of the matching window.
- R6: When several windows match, the one with the lowest index decides the route.
- R7: If the deciding window holds link code 3, the response has the error flag high, the hit flag low, and node and link at zero.
- R8: The non-posted output is high only for a hit that is a write from the CPU, where the deciding window has upper-bound bit 7 set. It is low for reads, for writes from other sources and for windows with bit 7 clear.
- R9: Lower-bound bit 3 locks a pair. After it is set, writes to either register of that pair leave both unchanged until reset. Other pairs stay writable.
- R10: The response valid flag is high exactly in the cycle after a cycle with the request valid input high. When valid is low, hit, error and non-posted are low.
- R11: Unused register bits always read back as zero. In the lower bound these are bits 7:4. In the upper bound these are bits 6 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Window index for register access |
| cfg_upper | input | 1 | 1 selects the upper-bound register, 0 selects the lower-bound register |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| req_valid | input | 1 | Request present |
| req_addr | input | 40 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_from_cpu | input | 1 | Request issued by the CPU |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | A window claimed the request with a usable route |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_nonposted | output | 1 | CPU write has to be issued non-posted |
| rsp_err | output | 1 | Deciding window holds the reserved link code |

## Verification
The hardest case to reach is overlapping windows, where a lower-indexed window has to win over a higher one. The same is true when that overlap is combined with a locked pair that software then tries to move. The stimulus programs two windows over one page with different nodes and sends a request into the shared page. It then locks a third window and tries writes to both of its registers. It checks the read-back values and also confirms that the locked window still routes requests.

// File: rtl/mmio_route_pkg.sv
// Package: shared widths and the decoded per-window configuration type.
// Assumes 40-bit request addresses compared at 64 KB page granularity.
package mmio_route_pkg;
    localparam int ADDR_W   = 40;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int NODE_W   = 3;
    localparam int LINK_W   = 2;
    localparam int REG_W    = 32;
    localparam logic [LINK_W-1:0] LINK_RSVD = 2'b11;

    typedef struct packed {
        logic [PAGE_W-1:0] lo_page;
        logic [PAGE_W-1:0] hi_page;
        logic              rd_en;
        logic              wr_en;
        logic              cpu_off;
        logic              locked;
        logic [NODE_W-1:0] node;
        logic [LINK_W-1:0] link;
        logic              force_np;
    } win_cfg_t;
endpackage

// File: rtl/mmio_route_regs.sv
// Module: window register file.
// Holds one lower/upper register pair per window and applies the per-pair lock.
// Assumes a register write takes effect at the clock edge where cfg_we is high.
module mmio_route_regs
    import mmio_route_pkg::*;
#(
    parameter int N_PAIRS = 8,
    localparam int IDX_W = $clog2(N_PAIRS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic                      cfg_upper,
    input  logic [REG_W-1:0]          cfg_wdata,
    output logic [REG_W-1:0]          cfg_rdata,
    output win_cfg_t [N_PAIRS-1:0]    win_cfg,
    output logic [N_PAIRS-1:0]        lock_vec
);
    win_cfg_t [N_PAIRS-1:0] cfg_q;

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
        logic sel_me;
        assign sel_me = cfg_we && (cfg_idx == IDX_W'(g)) && !cfg_q[g].locked;

        // Update this pair's fields on an unlocked write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (sel_me && !cfg_upper) begin
                cfg_q[g].lo_page <= cfg_wdata[REG_W-1:8];
                cfg_q[g].rd_en   <= cfg_wdata[0];
                cfg_q[g].wr_en   <= cfg_wdata[1];
                cfg_q[g].cpu_off <= cfg_wdata[2];
                cfg_q[g].locked  <= cfg_wdata[3];
            end else if (sel_me && cfg_upper) begin
                cfg_q[g].hi_page  <= cfg_wdata[REG_W-1:8];
                cfg_q[g].force_np <= cfg_wdata[7];
                cfg_q[g].link     <= cfg_wdata[5:4];
                cfg_q[g].node     <= cfg_wdata[2:0];
            end
        end

        assign lock_vec[g] = cfg_q[g].locked;
    end

    assign win_cfg = cfg_q;

    // Present the selected register with unused bits at zero.
    always_comb begin
        win_cfg_t s;
        s = cfg_q[cfg_idx];
        if (cfg_upper)
            cfg_rdata = {s.hi_page, s.force_np, 1'b0, s.link, 1'b0, s.node};
        else
            cfg_rdata = {s.lo_page, 4'b0, s.locked, s.cpu_off, s.wr_en, s.rd_en};
    end
endmodule

// File: rtl/mmio_route_match.sv
// Module: single-window comparator.
// Decides whether one window claims a request from its bounds, enables and CPU exclusion.
// Assumes the request page is already extracted from the address.
module mmio_route_match
    import mmio_route_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    input  logic              from_cpu,
    output logic              hit
);
    logic in_range;
    logic type_ok;

    // Inclusive bound check and enable check for the request type.
    always_comb begin
        in_range = (page >= cfg.lo_page) && (page <= cfg.hi_page);
        type_ok  = is_write ? cfg.wr_en : cfg.rd_en;
        hit      = in_range && type_ok && !(from_cpu && cfg.cpu_off);
    end
endmodule

// File: rtl/mmio_route_pick.sv
// Module: fixed-priority selector.
// Returns the lowest-index window that matched, plus a flag saying whether any matched.
module mmio_route_pick #(
    parameter int N_PAIRS = 8,
    localparam int IDX_W = $clog2(N_PAIRS)
) (
    input  logic [N_PAIRS-1:0] hit_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   win_idx
);
    // Scan from the top down so the lowest matching index is the last one assigned.
    always_comb begin
        win_idx = '0;
        for (int i = N_PAIRS - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
        any_hit = |hit_vec;
    end
endmodule

// File: rtl/mmio_route_top.sv
// Module: memory-mapped I/O range router top.
// Compares each request against all windows in parallel, picks the lowest-index match
// and registers the route one cycle after the request.
// Assumes at most one request per cycle and no back-pressure.
module mmio_route_top
    import mmio_route_pkg::*;
#(
    parameter int N_PAIRS = 8,
    localparam int IDX_W = $clog2(N_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_upper,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_from_cpu,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NODE_W-1:0] rsp_node,
    output logic [LINK_W-1:0] rsp_link,
    output logic              rsp_nonposted,
    output logic              rsp_err
);
    win_cfg_t [N_PAIRS-1:0] win_cfg;
    logic [N_PAIRS-1:0]     lock_vec;
    logic [N_PAIRS-1:0]     hit_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [PAGE_W-1:0]      req_page;

    assign req_page = req_addr[ADDR_W-1:PAGE_LSB];

    mmio_route_regs #(.N_PAIRS(N_PAIRS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_upper (cfg_upper),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_cfg   (win_cfg),
        .lock_vec  (lock_vec)
    );

    for (genvar g = 0; g < N_PAIRS; g++) begin : g_match
        mmio_route_match match_i (
            .cfg      (win_cfg[g]),
            .page     (req_page),
            .is_write (req_write),
            .from_cpu (req_from_cpu),
            .hit      (hit_vec[g])
        );
    end

    mmio_route_pick #(.N_PAIRS(N_PAIRS)) pick_i (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    // Register the route for a valid request; the reserved link code turns into an error.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid     <= rst_n && req_valid;
            rsp_hit       <= 1'b0;
            rsp_err       <= 1'b0;
            rsp_node      <= '0;
            rsp_link      <= '0;
            rsp_nonposted <= 1'b0;
        end else begin
            rsp_valid <= 1'b1;
            if (any_hit && win_cfg[win_idx].link != LINK_RSVD) begin
                rsp_hit       <= 1'b1;
                rsp_err       <= 1'b0;
                rsp_node      <= win_cfg[win_idx].node;
                rsp_link      <= win_cfg[win_idx].link;
                rsp_nonposted <= req_write && req_from_cpu && win_cfg[win_idx].force_np;
            end else begin
                rsp_hit       <= 1'b0;
                rsp_err       <= any_hit;
                rsp_node      <= '0;
                rsp_link      <= '0;
                rsp_nonposted <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mmio_route_chk.sv
// Module: protocol checker for the router, attached to the top through bind.
module mmio_route_chk #(
    parameter int N_PAIRS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_from_cpu,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_err,
    input logic               rsp_nonposted,
    input logic [N_PAIRS-1:0] lock_vec
);
    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit && !rsp_err && !rsp_nonposted);

    assert_hit_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_err));

    assert_np_cpu_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_write && req_from_cpu) |=> !rsp_nonposted);

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_vec) & ~lock_vec) == '0);
endmodule

bind mmio_route_top mmio_route_chk #(.N_PAIRS(N_PAIRS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_from_cpu  (req_from_cpu),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_err       (rsp_err),
    .rsp_nonposted (rsp_nonposted),
    .lock_vec      (lock_vec)
);

// File: tb/mmio_route_top_tb_top.sv
// Directed bench for the router: one task per scenario, each checking its own results.
module mmio_route_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_upper = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_from_cpu = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_nonposted, rsp_err;
    logic [2:0]  rsp_node;
    logic [1:0]  rsp_link;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmio_route_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_from_cpu(req_from_cpu), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_node(rsp_node), .rsp_link(rsp_link), .rsp_nonposted(rsp_nonposted),
        .rsp_err(rsp_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_val(input logic [23:0] pg, input bit lk,
                                           input bit cpu_off, input bit we, input bit re);
        return {pg, 4'b0, lk, cpu_off, we, re};
    endfunction

    function automatic logic [31:0] hi_val(input logic [23:0] pg, input bit np,
                                           input logic [1:0] link, input logic [2:0] node);
        return {pg, np, 1'b0, link, 1'b0, node};
    endfunction

    task automatic wr(input int idx, input bit upper, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_upper = upper; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input string req, input int idx, input bit upper, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = 3'(idx); cfg_upper = upper;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Issue one request and compare the response in the following cycle.
    task automatic probe(input string req, input logic [39:0] a, input bit w, input bit cpu,
                         input bit e_hit, input logic [2:0] e_node, input logic [1:0] e_link,
                         input bit e_np, input bit e_err);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_from_cpu = cpu;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " hit"}, 32'(rsp_hit), 32'(e_hit));
        check({req, " node"}, 32'(rsp_node), 32'(e_node));
        check({req, " link"}, 32'(rsp_link), 32'(e_link));
        check({req, " np"}, 32'(rsp_nonposted), 32'(e_np));
        check({req, " err"}, 32'(rsp_err), 32'(e_err));
    endtask

    function automatic logic [39:0] at(input logic [23:0] pg, input logic [15:0] off);
        return {pg, off};
    endfunction

    task automatic t_reset;
        for (int i = 0; i < 8; i++) begin
            rd("R1 lower reset", i, 1'b0, 32'h0);
            rd("R1 upper reset", i, 1'b1, 32'h0);
        end
        @(negedge clk);
        check("R10 idle valid", 32'(rsp_valid), 32'd0);
        probe("R1 no route", at(24'h0, 16'h0), 1'b0, 1'b0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R10 valid drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_mask;
        wr(0, 1'b0, 32'hFFFF_FFF7);
        rd("R11 lower mask", 0, 1'b0, 32'hFFFF_FF07);
        wr(0, 1'b1, 32'hFFFF_FFFF);
        rd("R11 upper mask", 0, 1'b1, 32'hFFFF_FFB7);
        wr(0, 1'b0, 32'h0);
        wr(0, 1'b1, 32'h0);
    endtask

    task automatic t_range;
        wr(2, 1'b1, hi_val(24'h00010F, 0, 2'd1, 3'd5));
        wr(2, 1'b0, lo_val(24'h000100, 0, 0, 1, 1));
        probe("R2 R5 low edge", at(24'h100, 16'h0), 0, 0, 1, 3'd5, 2'd1, 0, 0);
        probe("R2 high edge", at(24'h10F, 16'hFFFF), 1, 0, 1, 3'd5, 2'd1, 0, 0);
        probe("R2 below", at(24'h0FF, 16'hFFFF), 0, 0, 0, 0, 0, 0, 0);
        probe("R2 above", at(24'h110, 16'h0), 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_enables;
        wr(3, 1'b1, hi_val(24'h000200, 0, 2'd2, 3'd1));
        wr(3, 1'b0, lo_val(24'h000200, 0, 0, 1, 0));
        probe("R3 read off", at(24'h200, 16'h10), 0, 0, 0, 0, 0, 0, 0);
        probe("R3 write on", at(24'h200, 16'h10), 1, 0, 1, 3'd1, 2'd2, 0, 0);
    endtask

    task automatic t_cpu;
        wr(4, 1'b1, hi_val(24'h000300, 0, 2'd0, 3'd4));
        wr(4, 1'b0, lo_val(24'h000300, 0, 1, 1, 1));
        probe("R4 cpu excluded", at(24'h300, 16'h0), 0, 1, 0, 0, 0, 0, 0);
        probe("R4 other source", at(24'h300, 16'h0), 0, 0, 1, 3'd4, 2'd0, 0, 0);
    endtask

    task automatic t_prio;
        wr(5, 1'b1, hi_val(24'h000100, 0, 2'd2, 3'd7));
        wr(5, 1'b0, lo_val(24'h000100, 0, 0, 1, 1));
        probe("R6 two overlap", at(24'h100, 16'h20), 0, 0, 1, 3'd5, 2'd1, 0, 0);
        wr(6, 1'b1, hi_val(24'h000400, 0, 2'd1, 3'd6));
        wr(6, 1'b0, lo_val(24'h000400, 0, 0, 1, 1));
        wr(1, 1'b1, hi_val(24'h000400, 0, 2'd2, 3'd3));
        wr(1, 1'b0, lo_val(24'h000400, 0, 0, 1, 1));
        probe("R6 low index wins", at(24'h400, 16'h0), 0, 0, 1, 3'd3, 2'd2, 0, 0);
    endtask

    task automatic t_err;
        wr(0, 1'b1, hi_val(24'h000500, 0, 2'd3, 3'd2));
        wr(0, 1'b0, lo_val(24'h000500, 0, 0, 1, 1));
        probe("R7 reserved link", at(24'h500, 16'h0), 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_np;
        wr(7, 1'b1, hi_val(24'h000600, 1, 2'd0, 3'd2));
        wr(7, 1'b0, lo_val(24'h000600, 0, 0, 1, 1));
        probe("R8 cpu write np", at(24'h600, 16'h0), 1, 1, 1, 3'd2, 2'd0, 1, 0);
        probe("R8 dev write", at(24'h600, 16'h0), 1, 0, 1, 3'd2, 2'd0, 0, 0);
        probe("R8 cpu read", at(24'h600, 16'h0), 0, 1, 1, 3'd2, 2'd0, 0, 0);
        probe("R8 bit clear", at(24'h100, 16'h0), 1, 1, 1, 3'd5, 2'd1, 0, 0);
    endtask

    task automatic t_lock;
        wr(3, 1'b0, lo_val(24'h000200, 1, 0, 1, 0));
        rd("R9 lock set", 3, 1'b0, lo_val(24'h000200, 1, 0, 1, 0));
        wr(3, 1'b1, hi_val(24'h000700, 0, 2'd0, 3'd0));
        rd("R9 upper frozen", 3, 1'b1, hi_val(24'h000200, 0, 2'd2, 3'd1));
        wr(3, 1'b0, 32'h0);
        rd("R9 lower frozen", 3, 1'b0, lo_val(24'h000200, 1, 0, 1, 0));
        probe("R9 locked routes", at(24'h200, 16'h0), 1, 0, 1, 3'd1, 2'd2, 0, 0);
        wr(5, 1'b1, hi_val(24'h000101, 0, 2'd2, 3'd7));
        rd("R9 other pair open", 5, 1'b1, hi_val(24'h000101, 0, 2'd2, 3'd7));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_range();
        t_enables();
        t_cpu();
        t_prio();
        t_err();
        t_np();
        t_lock();
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (200000) @(posedge clk);
        join_any
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule